// File: doc/BRIEF.md
# Prioritized Peripheral Interrupt Controller

This block collects level-sensitive interrupt requests from two external pins and a set of on-chip peripherals. Each source has a fixed core channel (0 to 6), set by a parameter table. On every clock edge the block picks one winner among the sources that are pending and allowed. It raises the matching core channel line and presents a service vector that names the winning source. Both outputs are registered.

Gating happens at three levels. A priority word holds one enable bit per channel and one enable bit per external pin. A two-bit mask level sits above the priority word and blocks the low channels, or every channel at its top setting. Software loads both through a small write port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `core_ch_req` is 0 and `isr_vec` is 0. All channel and pin enables are cleared and the mask level is 00, so no request is raised until software enables it.
- R2: A write with `wr_en`=1 lands at the clock edge. Address 0 loads the priority word: bits [6:0] are the channel 6..0 enables, bit 7 enables pin A and bit 8 enables pin B. Address 1 loads the mask level from bits [1:0]. The new setting governs the outputs produced at the following edge.
- R3: `core_ch_req` has at most one bit set, and that bit is the channel of the winning source. It reflects the inputs sampled at the previous clock edge.
- R4: Among eligible sources, the one on the higher-numbered channel wins.
- R5: When eligible sources share a channel, the lower combined index wins. Combined index 0 is pin A, 1 is pin B, and 2+k is peripheral k. The default channel table, by combined index 0..13, is 5,4,0,0,1,1,2,2,3,3,6,6,0,1.
- R6: A source whose channel enable bit is clear never raises its channel line.
- R7: Pin A and pin B are gated by their own enable bits, each independent of the other.
- R8: Mask level 00 blocks nothing, 01 blocks channel 0, 10 blocks channels 0 and 1, and 11 blocks every channel.
- R9: `isr_vec` is the winner's combined index plus 1. It is 0 exactly when no channel line is raised.
- R10: While the current winner stays eligible and remains the best channel, its vector is kept. This holds even when a lower-index source on the same channel becomes pending.
- R11: Requests are level-sensitive. The channel line and vector drop, or move to the next winner, one edge after the request clears or is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| periph_irq | input | NUM_PERIPH (12) | Peripheral request levels |
| ext_irq_a | input | 1 | External pin A request level |
| ext_irq_b | input | 1 | External pin B request level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = priority word, 1 = mask level |
| wr_data | input | 16 | Write data |
| core_ch_req | output | 7 | One-hot core channel request lines |
| isr_vec | output | 4 | Service vector, 0 = none |

## Verification
A change on the request inputs shows up on `core_ch_req` and `isr_vec` after one clock edge. A register write needs two edges: one to load the register and one to register the outputs. The bench drives inputs on the falling edge and steps exactly one rising edge per request change, or two per write. It samples on the following falling edge, so each check looks at the cycle in which the result first becomes due. The hold and release cases are checked cycle by cycle, with no extra settling steps.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_CH   = 7;
  localparam int CH_W     = 3;
  localparam int DATA_W   = 16;
  localparam logic ADDR_PRIO = 1'b0;
  localparam logic ADDR_MASK = 1'b1;

  typedef struct packed {
    logic [NUM_CH-1:0] ch_en;
    logic              pin_a_en;
    logic              pin_b_en;
    logic [1:0]        mask_lvl;
  } irq_cfg_t;

  // Lowest channel that passes at a given mask level; 7 passes nothing.
  function automatic logic [CH_W-1:0] mask_floor(input logic [1:0] lvl);
    case (lvl)
      2'b00:   return 3'd0;
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output irq_cfg_t          cfg
);
  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:NUM_CH+2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_PRIO) begin
        cfg.ch_en    <= wr_data[NUM_CH-1:0];
        cfg.pin_a_en <= wr_data[NUM_CH];
        cfg.pin_b_en <= wr_data[NUM_CH+1];
      end else begin
        cfg.mask_lvl <= wr_data[1:0];
      end
    end
  end
endmodule

// File: rtl/irq_eligibility.sv
module irq_eligibility
  import irq_pkg::*;
#(
  parameter int NSRC = 14,
  parameter logic [NSRC*CH_W-1:0] SRC_CH = '0
)(
  input  logic [NSRC-1:0] src_req,
  input  irq_cfg_t        cfg,
  output logic [NSRC-1:0] elig
);
  logic [CH_W-1:0] floor_ch;
  assign floor_ch = mask_floor(cfg.mask_lvl);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam logic [CH_W-1:0] C = SRC_CH[CH_W*s +: CH_W];
    logic pin_gate;
    if (s == 0) begin : g_pa
      assign pin_gate = cfg.pin_a_en;
    end else if (s == 1) begin : g_pb
      assign pin_gate = cfg.pin_b_en;
    end else begin : g_per
      assign pin_gate = 1'b1;
    end
    assign elig[s] = src_req[s] & cfg.ch_en[C] & (C >= floor_ch) & pin_gate;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NSRC = 14,
  parameter logic [NSRC*CH_W-1:0] SRC_CH = '0,
  localparam int IDX_W = $clog2(NSRC)
)(
  input  logic [NSRC-1:0]  elig,
  output logic             best_valid,
  output logic [CH_W-1:0]  best_ch,
  output logic [IDX_W-1:0] best_idx
);
  logic [NUM_CH-1:0] ch_hit;
  logic [IDX_W-1:0]  ch_idx [NUM_CH];

  // Per channel: lowest eligible index (scan downward so lowest is last).
  always_comb begin
    ch_hit = '0;
    for (int c = 0; c < NUM_CH; c++) ch_idx[c] = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (elig[s] && (SRC_CH[CH_W*s +: CH_W] == CH_W'(c))) begin
          ch_hit[c] = 1'b1;
          ch_idx[c] = IDX_W'(s);
        end
      end
    end
  end

  // Across channels: highest channel wins.
  always_comb begin
    best_valid = 1'b0;
    best_ch    = '0;
    best_idx   = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_hit[c]) begin
        best_valid = 1'b1;
        best_ch    = CH_W'(c);
        best_idx   = ch_idx[c];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_PERIPH = 12,
  localparam int NSRC  = NUM_PERIPH + 2,
  localparam int IDX_W = $clog2(NSRC),
  localparam int VEC_W = $clog2(NSRC + 1),
  parameter logic [NSRC*CH_W-1:0] SRC_CH =
    {3'd1, 3'd0, 3'd6, 3'd6, 3'd3, 3'd3, 3'd2,
     3'd2, 3'd1, 3'd1, 3'd0, 3'd0, 3'd4, 3'd5}
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PERIPH-1:0] periph_irq,
  input  logic                  ext_irq_a,
  input  logic                  ext_irq_b,
  input  logic                  wr_en,
  input  logic                  wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [NUM_CH-1:0]     core_ch_req,
  output logic [VEC_W-1:0]      isr_vec
);
  irq_cfg_t         cfg;
  logic [NSRC-1:0]  src_req;
  logic [NSRC-1:0]  elig;
  logic             best_valid;
  logic [CH_W-1:0]  best_ch;
  logic [IDX_W-1:0] best_idx;
  logic [CH_W-1:0]  held_ch_q;
  logic [IDX_W-1:0] held_idx_q;
  logic             held_elig;
  logic             keep_holder;

  assign src_req = {periph_irq, ext_irq_b, ext_irq_a};

  irq_cfg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg)
  );

  irq_eligibility #(.NSRC(NSRC), .SRC_CH(SRC_CH)) u_elig (
    .src_req(src_req), .cfg(cfg), .elig(elig)
  );

  irq_arbiter #(.NSRC(NSRC), .SRC_CH(SRC_CH)) u_arb (
    .elig(elig), .best_valid(best_valid), .best_ch(best_ch),
    .best_idx(best_idx)
  );

  always_comb begin
    held_elig = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (held_idx_q == IDX_W'(s)) held_elig = elig[s];
    end
  end

  assign keep_holder = (isr_vec != '0) && held_elig && best_valid &&
                       (best_ch == held_ch_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      core_ch_req <= '0;
      isr_vec     <= '0;
      held_ch_q   <= '0;
      held_idx_q  <= '0;
    end else if (keep_holder) begin
      core_ch_req <= NUM_CH'(1) << held_ch_q;
    end else if (best_valid) begin
      core_ch_req <= NUM_CH'(1) << best_ch;
      isr_vec     <= VEC_W'(best_idx) + VEC_W'(1);
      held_ch_q   <= best_ch;
      held_idx_q  <= best_idx;
    end else begin
      core_ch_req <= '0;
      isr_vec     <= '0;
    end
  end

  // R3: at most one channel line raised
  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_ch_req));

  // R9: vector is zero exactly when no line is raised
  p_none_code_r9: assert property (@(posedge clk) disable iff (rst)
    (core_ch_req == '0) |-> (isr_vec == '0));
  p_some_code_r9: assert property (@(posedge clk) disable iff (rst)
    (core_ch_req != '0) |-> (isr_vec != '0));

  // R6: a disabled channel is never raised on the next edge
  p_block_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((core_ch_req & ~$past(cfg.ch_en)) == '0));

  // R8: top mask level silences every line
  p_mask_all_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg.mask_lvl == 2'b11) |=> (core_ch_req == '0));

  // R11: no eligible source means lines drop at the next edge
  p_drop_r11: assert property (@(posedge clk) disable iff (rst)
    !best_valid |=> (core_ch_req == '0));
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] periph_irq;
  logic        ext_irq_a, ext_irq_b;
  logic        wr_en, wr_addr;
  logic [15:0] wr_data;
  logic [6:0]  core_ch_req;
  logic [3:0]  isr_vec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst(rst), .periph_irq(periph_irq),
    .ext_irq_a(ext_irq_a), .ext_irq_b(ext_irq_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .core_ch_req(core_ch_req), .isr_vec(isr_vec)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [6:0] exp_ch,
                     input logic [3:0] exp_vec);
    checks++;
    if (core_ch_req !== exp_ch || isr_vec !== exp_vec) begin
      failures++;
      $display("FAIL %s: ch=%b vec=%0d expected ch=%b vec=%0d",
               req, core_ch_req, isr_vec, exp_ch, exp_vec);
    end
  endtask

  // Write lands at the next edge; outputs reflect it one edge later.
  task automatic write_reg(input logic a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic clear_reqs();
    periph_irq = '0; ext_irq_a = 0; ext_irq_b = 0;
    step();
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", 7'b0, 4'd0);
    periph_irq = 12'hFFF; ext_irq_a = 1; ext_irq_b = 1;
    step();
    chk("R1 enables cleared", 7'b0, 4'd0);
    clear_reqs();
  endtask

  task automatic t_write_basic();
    write_reg(1'b0, 16'h01FF);
    write_reg(1'b1, 16'h0000);
    periph_irq[0] = 1;
    step();
    chk("R2 R3 R9 periph0 on ch0", 7'b0000001, 4'd3);
  endtask

  task automatic t_priority();
    periph_irq[8] = 1;
    step();
    chk("R4 ch6 over ch0", 7'b1000000, 4'd11);
    clear_reqs();
    chk("R11 cleared", 7'b0, 4'd0);
  endtask

  task automatic t_same_channel();
    periph_irq[1] = 1; periph_irq[10] = 1;
    step();
    chk("R5 lower index on ch0", 7'b0000001, 4'd4);
    clear_reqs();
  endtask

  task automatic t_hold();
    periph_irq[10] = 1;
    step();
    chk("R10 holder periph10", 7'b0000001, 4'd13);
    periph_irq[0] = 1;
    step();
    chk("R10 holder kept", 7'b0000001, 4'd13);
    periph_irq[10] = 0;
    step();
    chk("R11 handover on drop", 7'b0000001, 4'd3);
    clear_reqs();
  endtask

  task automatic t_channel_enable();
    write_reg(1'b0, 16'h01BF);
    periph_irq[8] = 1; periph_irq[0] = 1;
    step();
    chk("R6 ch6 disabled", 7'b0000001, 4'd3);
    write_reg(1'b0, 16'h01FF);
    chk("R2 write not yet visible", 7'b0000001, 4'd3);
    step();
    chk("R6 ch6 re-enabled", 7'b1000000, 4'd11);
    clear_reqs();
  endtask

  task automatic t_pins();
    ext_irq_a = 1; ext_irq_b = 1;
    step();
    chk("R7 pin A on ch5", 7'b0100000, 4'd1);
    write_reg(1'b0, 16'h017F);
    step();
    chk("R7 pin A off, B on ch4", 7'b0010000, 4'd2);
    write_reg(1'b0, 16'h007F);
    step();
    chk("R7 both pins off", 7'b0, 4'd0);
    write_reg(1'b0, 16'h01FF);
    clear_reqs();
  endtask

  task automatic t_mask();
    periph_irq[0] = 1; periph_irq[2] = 1;
    step();
    chk("R8 level 00", 7'b0000010, 4'd5);
    write_reg(1'b1, 16'h0001);
    step();
    chk("R8 level 01 ch1 passes", 7'b0000010, 4'd5);
    periph_irq[2] = 0;
    step();
    chk("R8 level 01 ch0 blocked", 7'b0, 4'd0);
    periph_irq[2] = 1;
    write_reg(1'b1, 16'h0002);
    step();
    chk("R8 level 10 ch1 blocked", 7'b0, 4'd0);
    ext_irq_a = 1;
    step();
    chk("R8 level 10 ch5 passes", 7'b0100000, 4'd1);
    write_reg(1'b1, 16'h0003);
    step();
    chk("R8 level 11 all blocked", 7'b0, 4'd0);
    write_reg(1'b1, 16'h0000);
    step();
    chk("R8 unmasked again", 7'b0100000, 4'd1);
    clear_reqs();
    chk("R11 final drop", 7'b0, 4'd0);
  endtask

  initial begin
    rst = 1; periph_irq = '0; ext_irq_a = 0; ext_irq_b = 0;
    wr_en = 0; wr_addr = 0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_write_basic();
    t_priority();
    t_same_channel();
    t_hold();
    t_channel_enable();
    t_pins();
    t_mask();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule